// File: doc/BRIEF.md
# Bus Wait-State Controller

This block sets the number of wait clocks (TW) added to each cycle on a small processor bus. It keeps one programmed wait count for each kind of bus master cycle: CPU memory, DMA and refresh. When a cycle starts it takes the count for that cycle's type. It then merges that count with an external READY line, so the longer of the two requests sets how far the cycle is stretched.

The bus interface pulses `cyc_start` during T1 and gives the cycle type. The clock after T1 is T2. At the end of T2 the block loads a countdown with the count it captured. From then on it holds the cycle in TW until the countdown is empty and the synchronized READY is high. After that the cycle moves to a single T3 clock. The wait fields are written through a small register write port. READY comes from outside and passes through a flop synchronizer inside the block before it is used.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, every programmed wait field holds 3, and `wait_active` and `in_t3` are low.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the field that `cfg_sel` picks: 0 is CPU memory, 1 is DMA, 2 is refresh. A write with `cfg_sel` = 3 changes no field.
- R3: A cycle with `cyc_type` = 0 (CPU memory) and READY held high inserts exactly the CPU memory field's count of TW clocks.
- R4: Cycles with `cyc_type` = 1 (DMA) and `cyc_type` = 2 (refresh) each insert the count from their own field, and neither uses another type's field.
- R5: A cycle with `cyc_type` = 3 has a programmed count of zero, so only READY can stretch it.
- R6: When READY is low at the end of T2 and at the end of the first n−1 TW clocks, the number of TW clocks is the larger of n and the programmed count.
- R7: `ready_in` reaches the wait decision through SYNC_STAGES flops. The decision made at a clock edge uses the level `ready_in` had SYNC_STAGES edges earlier.
- R8: The clock after the `cyc_start` clock is T2. The TW clocks follow. T3 is then exactly one clock, starting 2 + waits clocks after the `cyc_start` clock, and the block goes idle after it.
- R9: The wait field is captured when the cycle starts. A write to that field later in the same cycle takes effect from the next cycle.
- R10: A `cyc_start` pulse while a cycle is in progress is ignored. It neither restarts nor changes the running cycle and does not start a new one.
- R11: `wait_active` is high during each TW clock and only then. It is never high in the same clock as `in_t3`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Wait field write strobe |
| cfg_sel | input | 2 | Wait field select (0 CPU memory, 1 DMA, 2 refresh) |
| cfg_wdata | input | WAIT_W | Wait count to store |
| cyc_start | input | 1 | High during T1 of a new bus cycle |
| cyc_type | input | 2 | Cycle type, sampled with cyc_start |
| ready_in | input | 1 | External READY, asynchronous to clk |
| wait_active | output | 1 | High during each inserted TW clock |
| in_t3 | output | 1 | High during the T3 clock of the cycle |

## Verification
The bench builds the block with its default parameters: a 2-bit wait field (0 to 3 clocks), three programmed cycle types plus the unmanaged code, and a two-flop READY synchronizer. With these values it can cover every programmed count, READY windows both shorter and longer than the largest programmed count (up to five clocks), and a READY dip timed so that the synchronizer delay moves it past T2. Each cycle is scored by counting the TW clocks and by the clock in which T3 appears. Separate cycles cover a write in the middle of a cycle, a start pulse while busy, and a write to the unused select code.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int unsigned CT_W = 2;

  typedef enum logic [CT_W-1:0] {
    BC_CPU_MEM = 2'd0,
    BC_DMA     = 2'd1,
    BC_REFRESH = 2'd2,
    BC_PLAIN   = 2'd3
  } bus_cyc_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T2   = 2'd1,
    PH_TW   = 2'd2,
    PH_T3   = 2'd3
  } bus_phase_e;
endpackage

// File: rtl/bwc_wait_cfg.sv
module bwc_wait_cfg #(
  parameter int unsigned N_TYPES     = 3,
  parameter int unsigned WAIT_W      = 2,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned RESET_WAITS = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [WAIT_W-1:0]                wr_val,
  output logic [N_TYPES-1:0][WAIT_W-1:0]   fields
);
  localparam logic [WAIT_W-1:0] RST_VAL = WAIT_W'(RESET_WAITS);

  for (genvar g = 0; g < N_TYPES; g++) begin : g_field
    logic              fld_en;
    logic [WAIT_W-1:0] fld_d;
    logic [WAIT_W-1:0] fld_q;

    always_comb begin
      fld_en = wr_en && (wr_sel == SEL_W'(g));
      fld_d  = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q <= RST_VAL;
      end else if (fld_en) begin
        fld_q <= fld_d;
      end
    end

    assign fields[g] = fld_q;

    // R2
    cfg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(g)) |=> (fields[g] == $past(wr_val)));
  end
endmodule

// File: rtl/bwc_ready_sync.sv
module bwc_ready_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_in,
  output logic ready_s
);
  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], ready_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign ready_s = chain_q[STAGES-1];

  if (STAGES == 2) begin : g_lag_chk
    // R7
    sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ready_s)) |-> (!$past(ready_in, 2)));
  end
endmodule

// File: rtl/bwc_wait_seq.sv
module bwc_wait_seq
  import bwc_pkg::*;
#(
  parameter int unsigned N_TYPES = 3,
  parameter int unsigned WAIT_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cyc_start,
  input  logic [CT_W-1:0]                cyc_type,
  input  logic [N_TYPES-1:0][WAIT_W-1:0] fields,
  input  logic                           ready_s,
  output logic                           wait_active,
  output logic                           in_t3
);
  bus_phase_e        ph_d, ph_q;
  logic [WAIT_W-1:0] cnt_d, cnt_q;
  logic [WAIT_W-1:0] sel_d, sel_q;
  logic [WAIT_W-1:0] picked;
  logic [WAIT_W-1:0] cnt_dec;
  logic              sel_en;
  logic              cnt_en;

  always_comb begin
    picked = '0;
    for (int i = 0; i < N_TYPES; i++) begin
      if (cyc_type == CT_W'(i)) picked = fields[i];
    end
  end

  always_comb begin
    cnt_dec = (cnt_q != '0) ? (cnt_q - WAIT_W'(1)) : '0;
    sel_en  = (ph_q == PH_IDLE) && cyc_start;
    sel_d   = picked;
    cnt_en  = (ph_q == PH_T2) || (ph_q == PH_TW);
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    unique case (ph_q)
      PH_IDLE: if (cyc_start) ph_d = PH_T2;
      PH_T2: begin
        cnt_d = sel_q;
        ph_d  = (sel_q == '0 && ready_s) ? PH_T3 : PH_TW;
      end
      PH_TW: begin
        cnt_d = cnt_dec;
        if (cnt_dec == '0 && ready_s) ph_d = PH_T3;
      end
      PH_T3:   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign wait_active = (ph_q == PH_TW);
  assign in_t3       = (ph_q == PH_T3);

  // R6
  t3_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_t3) |-> $past(ready_s));

  // R6
  count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_active && cnt_q > WAIT_W'(1)) |=> wait_active);

  // R8
  t3_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_t3 |=> (!in_t3 && !wait_active));

  // R8
  t2_then_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && cyc_start) |=> ##1 (wait_active || in_t3));
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int unsigned WAIT_W      = 2,
  parameter int unsigned N_TYPES     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RESET_WAITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CT_W-1:0]   cfg_sel,
  input  logic [WAIT_W-1:0] cfg_wdata,
  input  logic              cyc_start,
  input  logic [CT_W-1:0]   cyc_type,
  input  logic              ready_in,
  output logic              wait_active,
  output logic              in_t3
);
  logic [N_TYPES-1:0][WAIT_W-1:0] fields;
  logic                           ready_s;

  bwc_wait_cfg #(
    .N_TYPES    (N_TYPES),
    .WAIT_W     (WAIT_W),
    .SEL_W      (CT_W),
    .RESET_WAITS(RESET_WAITS)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_we),
    .wr_sel(cfg_sel),
    .wr_val(cfg_wdata),
    .fields(fields)
  );

  bwc_ready_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_in(ready_in),
    .ready_s (ready_s)
  );

  bwc_wait_seq #(
    .N_TYPES(N_TYPES),
    .WAIT_W (WAIT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .cyc_type   (cyc_type),
    .fields     (fields),
    .ready_s    (ready_s),
    .wait_active(wait_active),
    .in_t3      (in_t3)
  );
endmodule

// File: tb/tb_bus_wait_ctrl.sv
module tb_bus_wait_ctrl;
  localparam int SYNC = 2;
  localparam int NV   = 9;
  // {we, wsel[1:0], wval[1:0], ctype[1:0], rlow[2:0], exp[2:0]}
  localparam logic [12:0] VECS [NV] = '{
    {1'b1, 2'd0, 2'd1, 2'd0, 3'd0, 3'd1},  // R3 cpu=1
    {1'b1, 2'd1, 2'd2, 2'd1, 3'd0, 3'd2},  // R4 dma=2
    {1'b1, 2'd2, 2'd0, 2'd2, 3'd0, 3'd0},  // R4 refresh=0
    {1'b0, 2'd0, 2'd0, 2'd0, 3'd3, 3'd3},  // R6 ready longer than cpu
    {1'b0, 2'd0, 2'd0, 2'd2, 3'd2, 3'd2},  // R6 ready on refresh
    {1'b0, 2'd0, 2'd0, 2'd1, 3'd1, 3'd2},  // R6 programmed longer than ready
    {1'b0, 2'd0, 2'd0, 2'd3, 3'd0, 3'd0},  // R5 unmanaged type
    {1'b0, 2'd0, 2'd0, 2'd3, 3'd2, 3'd2},  // R5 unmanaged with ready
    {1'b1, 2'd0, 2'd3, 2'd0, 3'd5, 3'd5}   // R6 ready past max count
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [1:0] cfg_wdata;
  logic       cyc_start;
  logic [1:0] cyc_type;
  logic       ready_in;
  logic       wait_active;
  logic       in_t3;
  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bus_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .cyc_type(cyc_type),
    .ready_in(ready_in), .wait_active(wait_active), .in_t3(in_t3)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // k indexes the edge that ends T1 as 0; inputs set before edge k,
  // outputs sampled before edge k show the clock that edge ends.
  task automatic run_cyc(input string req, input logic [1:0] ct, input int rlow,
                         input int rshift, input int expw, input int wr_k,
                         input logic [1:0] wsel, input logic [1:0] wval, input int rs_k);
    int waits = 0;
    int t3k   = -99;
    int both  = 0;
    int ws    = 1 - SYNC + rshift;
    for (int k = 1 - SYNC; k <= 40 && t3k == -99; k++) begin
      @(negedge clk);
      if (wait_active) waits++;
      if (wait_active && in_t3) both++;
      if (in_t3) t3k = k;
      ready_in  = !(rlow > 0 && k >= ws && k < ws + rlow);
      cyc_start = (k == 0) || (k == rs_k);
      cyc_type  = (k == rs_k && k != 0) ? 2'd2 : ct;
      cfg_we    = (k == wr_k);
      cfg_sel   = wsel;
      cfg_wdata = wval;
    end
    @(negedge clk);
    ready_in = 1'b1; cyc_start = 1'b0; cfg_we = 1'b0;
    chk(req, "tw_count", waits, expw);
    chk("R8", "t3_edge", t3k, 2 + expw);
    chk("R11", "tw_with_t3", both, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    cyc_start = 1'b0; cyc_type = '0; ready_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "wait_active_in_reset", int'(wait_active), 0);
    chk("R1", "in_t3_in_reset", int'(in_t3), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 default of 3 on each type
    run_cyc("R1", 2'd0, 0, 0, 3, -99, 2'd0, 2'd0, -99);
    run_cyc("R1", 2'd1, 0, 0, 3, -99, 2'd0, 2'd0, -99);
    run_cyc("R1", 2'd2, 0, 0, 3, -99, 2'd0, 2'd0, -99);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v][12]) cfg_write(VECS[v][11:10], VECS[v][9:8]);
      run_cyc("R6", VECS[v][7:6], int'(VECS[v][5:3]), 0, int'(VECS[v][2:0]),
              -99, 2'd0, 2'd0, -99);
    end

    // R2 select 3 writes nothing: cpu=3, dma=2, refresh=0 remain
    cfg_write(2'd3, 2'd0);
    run_cyc("R2", 2'd0, 0, 0, 3, -99, 2'd0, 2'd0, -99);
    run_cyc("R2", 2'd1, 0, 0, 2, -99, 2'd0, 2'd0, -99);
    run_cyc("R2", 2'd2, 0, 0, 0, -99, 2'd0, 2'd0, -99);

    // R9 mid-cycle write uses old value now, new value next cycle
    cfg_write(2'd0, 2'd1);
    run_cyc("R9", 2'd0, 0, 0, 1, 1, 2'd0, 2'd3, -99);
    run_cyc("R9", 2'd0, 0, 0, 3, -99, 2'd0, 2'd0, -99);

    // R10 second start during the cycle is ignored
    run_cyc("R10", 2'd1, 0, 0, 2, -99, 2'd0, 2'd0, 2);
    begin
      int stray = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (wait_active || in_t3) stray++;
      end
      chk("R10", "stray_cycle", stray, 0);
    end

    // R7 one-clock READY dip at the end-of-T2 edge lands after the decision
    run_cyc("R7", 2'd2, 1, SYNC, 0, -99, 2'd0, 2'd0, -99);
    // R7 same dip timed SYNC edges earlier is seen at end of T2
    run_cyc("R7", 2'd2, 1, 0, 1, -99, 2'd0, 2'd0, -99);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule